// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block puts a small bank of configuration registers behind two I/O addresses. Software first writes a register number to the index port, then reads or writes that register through the data port. The pair of ports is the only way into the bank, so the whole register space costs two I/O addresses however many registers it holds.

Each register has an access class (read-only, write-only or read/write), a mask that says which bits a write may change, and a value it takes on reset. These come from a compile-time table in the package. Any register number that is not in the table is a reserved location. An access to a reserved location still completes, a read of it returns zero, and a write to it changes nothing. The register values drive the rest of the chip through a flat output vector.

The bus side is a simple strobe interface: an address, a one-cycle read or write strobe, write data, read data and a ready flag. An access to either port gets ready one clock after its strobe. An access to any other address is not claimed.

Top module: `cfg_index_port`

## Requirements
- R1: A write strobe at address 0x22 loads write data into the index register. A read strobe at 0x22 returns the index. The index is 0x00 after reset.
- R2: A read strobe at address 0x23 returns the register selected by the current index when that register is read/write or read-only. A write strobe at 0x23 updates the selected read/write register.
- R3: A data-port write changes only the bits set in the selected register's writable mask. Every other bit keeps its value.
- R4: A write to a read-only register changes no register value.
- R5: A read of a write-only register returns 0x00 and changes no state. A write to it updates its value on cfg_q.
- R6: When the index is not in the table, a data-port access still gets ready. A read returns 0x00 and a write changes no register.
- R7: After reset the table holds these entries, with cfg_q slot k at bits [8k+7:8k]:
  - slot0: index 0x02, read/write, mask 0xFF, reset 0x00
  - slot1: index 0x03, read/write, mask 0x3C, reset 0x81
  - slot2: index 0x08, read-only, reset 0xA5
  - slot3: index 0x09, write-only, mask 0xFF, reset 0x00
  - slot4: index 0x10, read/write, mask 0x0F, reset 0x05
- R8: io_ready is high exactly in the cycle after a strobe at 0x22 or 0x23. A strobe at any other address gives no ready and changes neither the index nor any register.
- R9: io_rdata is 0x00 in every cycle except the one that completes a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_ready is high |
| io_ready | output | 1 | Access complete, one cycle after the strobe |
| cfg_q | output | 40 | All register values, slot k at bits [8k+7:8k] |

## Verification
Every result of an access is due one clock edge after the strobe is sampled. The ready flag, the read data, the new index and the new register values all come from the same edge. The bench drives a strobe on a falling edge and holds it across one rising edge. It samples ready, read data and cfg_q on the next falling edge, so each check lands in the cycle the result is due. It then samples again one cycle later to confirm that ready and read data have returned to zero.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int CFG_DW    = 8;
  localparam int CFG_IW    = 8;
  localparam int NUM_SLOTS = 5;
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  typedef enum logic [1:0] {
    ACC_RSV = 2'd0,
    ACC_RO  = 2'd1,
    ACC_WO  = 2'd2,
    ACC_RW  = 2'd3
  } acc_t;

  typedef struct packed {
    logic [CFG_IW-1:0] idx;
    acc_t              acc;
    logic [CFG_DW-1:0] wmask;
    logic [CFG_DW-1:0] rstv;
  } slot_ent_t;

  // Compile-time register table; indices absent here are reserved.
  function automatic slot_ent_t slot_entry(int k);
    slot_ent_t e;
    case (k)
      0:       e = '{idx: 8'h02, acc: ACC_RW, wmask: 8'hFF, rstv: 8'h00};
      1:       e = '{idx: 8'h03, acc: ACC_RW, wmask: 8'h3C, rstv: 8'h81};
      2:       e = '{idx: 8'h08, acc: ACC_RO, wmask: 8'h00, rstv: 8'hA5};
      3:       e = '{idx: 8'h09, acc: ACC_WO, wmask: 8'hFF, rstv: 8'h00};
      4:       e = '{idx: 8'h10, acc: ACC_RW, wmask: 8'h0F, rstv: 8'h05};
      default: e = '{idx: '0,    acc: ACC_RSV, wmask: '0,   rstv: '0};
    endcase
    return e;
  endfunction

  function automatic logic [CFG_DW-1:0] merge_bits(
      input logic [CFG_DW-1:0] old_v,
      input logic [CFG_DW-1:0] new_v,
      input logic [CFG_DW-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic acc_writable(input acc_t a);
    return (a == ACC_RW) || (a == ACC_WO);
  endfunction

  function automatic logic acc_readable(input acc_t a);
    return (a == ACC_RW) || (a == ACC_RO);
  endfunction

endpackage

// File: rtl/cfgp_bus_decode.sv
module cfgp_bus_decode #(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              idx_wr_evt,
  output logic              idx_rd_evt,
  output logic              dat_wr_evt,
  output logic              dat_rd_evt,
  output logic              claim_evt,
  output logic              ready_q
);

  logic at_index;
  logic at_data;

  assign at_index   = (io_addr == INDEX_PORT);
  assign at_data    = (io_addr == DATA_PORT);
  assign idx_wr_evt = at_index & io_wr;
  assign idx_rd_evt = at_index & io_rd;
  assign dat_wr_evt = at_data  & io_wr;
  assign dat_rd_evt = at_data  & io_rd;
  assign claim_evt  = (at_index | at_data) & (io_rd | io_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= claim_evt;
  end

endmodule

// File: rtl/cfgp_index_reg.sv
module cfgp_index_reg #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] din,
  output logic [IW-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

endmodule

// File: rtl/cfgp_lookup.sv
module cfgp_lookup
  import cfgp_pkg::*;
(
  input  logic [CFG_IW-1:0] index,
  output logic              hit,
  output logic [SLOT_W-1:0] slot,
  output acc_t              acc
);

  always_comb begin
    hit  = 1'b0;
    slot = '0;
    acc  = ACC_RSV;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (index == slot_entry(k).idx) begin
        hit  = 1'b1;
        slot = SLOT_W'(k);
        acc  = slot_entry(k).acc;
      end
    end
  end

endmodule

// File: rtl/cfgp_slot.sv
module cfgp_slot
  import cfgp_pkg::*;
#(
  parameter acc_t              ACC   = ACC_RW,
  parameter logic [CFG_DW-1:0] WMASK = '1,
  parameter logic [CFG_DW-1:0] RSTV  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] q
);

  localparam logic CAN_WR = acc_writable(ACC);

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= RSTV;
    else if (wr_en && CAN_WR)
      q <= merge_bits(q, wdata, WMASK);
  end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgp_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           io_addr,
  input  logic                        io_rd,
  input  logic                        io_wr,
  input  logic [CFG_DW-1:0]           io_wdata,
  output logic [CFG_DW-1:0]           io_rdata,
  output logic                        io_ready,
  output logic [NUM_SLOTS*CFG_DW-1:0] cfg_q
);

  logic              idx_wr_evt, idx_rd_evt, dat_wr_evt, dat_rd_evt, claim_evt;
  logic [CFG_IW-1:0] cur_index;
  logic              sel_hit;
  logic [SLOT_W-1:0] sel_slot;
  acc_t              sel_acc;
  logic [CFG_DW-1:0] slot_q [NUM_SLOTS];
  logic [CFG_DW-1:0] rd_next;
  logic [CFG_DW-1:0] sel_val;

  cfgp_bus_decode #(
    .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .idx_wr_evt(idx_wr_evt), .idx_rd_evt(idx_rd_evt),
    .dat_wr_evt(dat_wr_evt), .dat_rd_evt(dat_rd_evt),
    .claim_evt(claim_evt), .ready_q(io_ready)
  );

  cfgp_index_reg #(.IW(CFG_IW)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(idx_wr_evt),
    .din(io_wdata[CFG_IW-1:0]), .q(cur_index)
  );

  cfgp_lookup u_lk (
    .index(cur_index), .hit(sel_hit), .slot(sel_slot), .acc(sel_acc)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam slot_ent_t ENT = slot_entry(k);
    logic wr_here;
    assign wr_here = dat_wr_evt && sel_hit && (sel_slot == SLOT_W'(k));
    cfgp_slot #(.ACC(ENT.acc), .WMASK(ENT.wmask), .RSTV(ENT.rstv)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_here), .wdata(io_wdata), .q(slot_q[k])
    );
    assign cfg_q[k*CFG_DW +: CFG_DW] = slot_q[k];
  end

  always_comb begin
    sel_val = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (sel_slot == SLOT_W'(k)) sel_val = slot_q[k];
  end

  always_comb begin
    rd_next = '0;
    if (idx_rd_evt)
      rd_next = CFG_DW'(cur_index);
    else if (dat_rd_evt && sel_hit && acc_readable(sel_acc))
      rd_next = sel_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) io_rdata <= '0;
    else        io_rdata <= rd_next;
  end

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
  import cfgp_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           io_addr,
  input logic                        io_rd,
  input logic                        io_wr,
  input logic [CFG_DW-1:0]           io_wdata,
  input logic [CFG_DW-1:0]           io_rdata,
  input logic                        io_ready,
  input logic [NUM_SLOTS*CFG_DW-1:0] cfg_q,
  input logic [CFG_IW-1:0]           cur_index,
  input logic                        idx_wr_evt,
  input logic                        dat_wr_evt,
  input logic                        dat_rd_evt,
  input logic                        sel_hit,
  input acc_t                        sel_acc
);

  logic claimed;
  assign claimed = (io_rd || io_wr) && (io_addr == INDEX_PORT || io_addr == DATA_PORT);

  AST_READY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    claimed |=> io_ready); // R8
  AST_UNCLAIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !claimed |=> !io_ready && $stable(cfg_q) && $stable(cur_index)); // R8
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr_evt |=> cur_index == $past(io_wdata[CFG_IW-1:0])); // R1
  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd_evt && !sel_hit) |=> io_rdata == '0); // R6
  AST_RSV_WRITE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_evt && !sel_hit) |=> $stable(cfg_q)); // R6
  AST_RO_WRITE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_evt && sel_acc == ACC_RO) |=> $stable(cfg_q)); // R4
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd_evt && sel_acc == ACC_WO) |=> io_rdata == '0); // R5
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && claimed) |=> io_rdata == '0); // R9

endmodule

bind cfg_index_port cfgp_checker #(
  .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready), .cfg_q(cfg_q),
  .cur_index(cur_index), .idx_wr_evt(idx_wr_evt), .dat_wr_evt(dat_wr_evt),
  .dat_rd_evt(dat_rd_evt), .sel_hit(sel_hit), .sel_acc(sel_acc)
);

// File: tb/sim_cfg_index_port.sv
`timescale 1ns/1ps
module sim_cfg_index_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_ready;
  logic [39:0] cfg_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Bench model of register values, slot order per R7
  logic [7:0] mdl [5];

  always #10 clk = ~clk;

  cfg_index_port u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready), .cfg_q(cfg_q)
  );

  function automatic logic [39:0] image();
    return {mdl[4], mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  // Bitwise masked update, written independently of the design
  function automatic logic [7:0] apply(input logic [7:0] o, input logic [7:0] n, input logic [7:0] m);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = m[b] ? n[b] : o[b];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic rd, input logic wr,
                        input logic [7:0] d, output logic [7:0] q, output logic rdy);
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
    @(negedge clk);
    q = io_rdata; rdy = io_ready;
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic set_index(input logic [7:0] i);
    logic [7:0] q; logic r;
    access(16'h0022, 1'b0, 1'b1, i, q, r);
  endtask

  task automatic t_reset();
    logic [7:0] q; logic r;
    mdl[0] = 8'h00; mdl[1] = 8'h81; mdl[2] = 8'hA5; mdl[3] = 8'h00; mdl[4] = 8'h05;
    check(cfg_q == image(), "R7 reset image", cfg_q, image());
    check(io_ready == 1'b0, "R8 ready low after reset", io_ready, 0);
    check(io_rdata == 8'h00, "R9 rdata zero after reset", io_rdata, 0);
    access(16'h0022, 1'b1, 1'b0, 8'h00, q, r);
    check(r && q == 8'h00, "R1 index resets to zero", {r, q}, {1'b1, 8'h00});
  endtask

  task automatic t_index();
    logic [7:0] q; logic r;
    access(16'h0022, 1'b0, 1'b1, 8'h5A, q, r);
    check(r == 1'b1, "R8 ready after index write", r, 1);
    check(q == 8'h00, "R9 rdata zero on write", q, 0);
    access(16'h0022, 1'b1, 1'b0, 8'h00, q, r);
    check(q == 8'h5A, "R1 index readback", q, 8'h5A);
    @(negedge clk);
    check(io_ready == 1'b0 && io_rdata == 8'h00, "R9 outputs clear after read",
          {io_ready, io_rdata}, 0);
  endtask

  task automatic t_rw();
    logic [7:0] q; logic r;
    set_index(8'h02);
    access(16'h0023, 1'b0, 1'b1, 8'hA7, q, r);
    mdl[0] = 8'hA7;
    check(cfg_q == image(), "R2 write full-mask register", cfg_q, image());
    access(16'h0023, 1'b1, 1'b0, 8'h00, q, r);
    check(r && q == 8'hA7, "R2 read back register", {r, q}, {1'b1, 8'hA7});
  endtask

  task automatic t_mask();
    logic [7:0] q; logic r;
    set_index(8'h03);
    access(16'h0023, 1'b0, 1'b1, 8'hFF, q, r);
    mdl[1] = apply(mdl[1], 8'hFF, 8'h3C);
    check(cfg_q == image(), "R3 only masked bits set", cfg_q, image());
    access(16'h0023, 1'b0, 1'b1, 8'h00, q, r);
    mdl[1] = apply(mdl[1], 8'h00, 8'h3C);
    access(16'h0023, 1'b1, 1'b0, 8'h00, q, r);
    check(q == mdl[1], "R3 fixed bits survive clear", q, mdl[1]);
    set_index(8'h10);
    access(16'h0023, 1'b0, 1'b1, 8'hF3, q, r);
    mdl[4] = apply(mdl[4], 8'hF3, 8'h0F);
    access(16'h0023, 1'b1, 1'b0, 8'h00, q, r);
    check(q == mdl[4] && cfg_q == image(), "R3 low-nibble mask", q, mdl[4]);
  endtask

  task automatic t_ro();
    logic [7:0] q; logic r;
    set_index(8'h08);
    access(16'h0023, 1'b1, 1'b0, 8'h00, q, r);
    check(q == 8'hA5, "R2 read-only register reads", q, 8'hA5);
    access(16'h0023, 1'b0, 1'b1, 8'h00, q, r);
    check(r == 1'b1 && cfg_q == image(), "R4 write to read-only ignored", cfg_q, image());
    access(16'h0023, 1'b1, 1'b0, 8'h00, q, r);
    check(q == 8'hA5, "R4 read-only value kept", q, 8'hA5);
  endtask

  task automatic t_wo();
    logic [7:0] q; logic r;
    set_index(8'h09);
    access(16'h0023, 1'b0, 1'b1, 8'h3C, q, r);
    mdl[3] = 8'h3C;
    check(cfg_q == image(), "R5 write-only updates", cfg_q, image());
    access(16'h0023, 1'b1, 1'b0, 8'h00, q, r);
    check(r && q == 8'h00, "R5 write-only reads zero", {r, q}, {1'b1, 8'h00});
    check(cfg_q == image(), "R5 read leaves state", cfg_q, image());
  endtask

  task automatic t_rsv();
    logic [7:0] q; logic r;
    foreach (mdl[i]) begin end
    set_index(8'h04);
    access(16'h0023, 1'b1, 1'b0, 8'h00, q, r);
    check(r && q == 8'h00, "R6 reserved read zero with ready", {r, q}, {1'b1, 8'h00});
    access(16'h0023, 1'b0, 1'b1, 8'hFF, q, r);
    check(r && cfg_q == image(), "R6 reserved write ignored", cfg_q, image());
    set_index(8'hFF);
    access(16'h0023, 1'b0, 1'b1, 8'h77, q, r);
    access(16'h0023, 1'b1, 1'b0, 8'h00, q, r);
    check(q == 8'h00 && cfg_q == image(), "R6 top index reserved", {q, cfg_q}, {8'h00, image()});
  endtask

  task automatic t_unclaimed();
    logic [7:0] q; logic r;
    set_index(8'h02);
    access(16'h0024, 1'b0, 1'b1, 8'h11, q, r);
    check(r == 1'b0, "R8 no ready for other address", r, 0);
    access(16'h0021, 1'b1, 1'b0, 8'h00, q, r);
    check(r == 1'b0 && q == 8'h00, "R8 R9 other address read quiet", {r, q}, 0);
    check(cfg_q == image(), "R8 registers untouched", cfg_q, image());
    access(16'h0022, 1'b1, 1'b0, 8'h00, q, r);
    check(q == 8'h02, "R8 index untouched", q, 8'h02);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_rw();
    t_mask();
    t_ro();
    t_wo();
    t_rsv();
    t_unclaimed();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule